// File: doc/BRIEF.md
# Power-Up Program Copier

This block runs once after reset and moves a program image from a read-only store into the working RAM of a small bus-based processor. While it runs it owns the shared data bus and the RAM control strobes. A manual-control output tells the normal instruction sequencer to keep its own control lines off.

Each word takes two clock cycles, paced by a phase bit that toggles every cycle. In the address cycle the copy counter is driven onto the bus and the RAM address register is loaded from it. In the data cycle the ROM word at that address, fetched by a synchronous read with one cycle of latency, is driven onto the bus and written into RAM. The counter then steps to the next address.

The copy ends when the ROM returns the all-ones end marker, or once the last address has been written. The loader then drops manual control. It also pulses a done strobe for one cycle, which clears the processor's program counter and step counter, so that execution begins at address 0.

Top module: `boot_loader`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, manualCtl=1, marLoad=1, ramWrite=0, bootDone=0, romAddr=0 and busOut=0.
- R2: In every address cycle (cycles 0, 2, 4 … after reset release while copying), marLoad=1, ramWrite=0, and busOut equals romAddr zero-extended.
- R3: In every data cycle (odd cycles) whose ROM word is not 0xFF, marLoad=0, ramWrite=1, and busOut equals the ROM word returned for the address presented in the previous cycle. That word therefore lands in RAM at that address.
- R4: romAddr starts at 0 and advances by exactly one after each data cycle that writes. It is held through the address and data cycles of a transfer.
- R5: A data cycle whose ROM word is 0xFF writes nothing (ramWrite=0). Only the words below the marker's address are written.
- R6: After the final data cycle, manualCtl, marLoad and ramWrite stay 0 and busOut stays 0 until the next reset.
- R7: bootDone is 1 for exactly one cycle: the first cycle in which manualCtl is 0. With the marker at address s, that is cycle 2s+2 after reset release.
- R8: With no marker, the copy stops after address 255 is written (256 words), and bootDone rises in cycle 512.
- R9: Asserting reset in the middle of a copy restarts it from address 0 with the R1 state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| romData | input | 8 | ROM read data, valid one cycle after romAddr |
| romAddr | output | 8 | ROM read address (copy counter) |
| busOut | output | 8 | Value the loader drives onto the shared bus; 0 when idle |
| marLoad | output | 1 | Load the bus into the RAM address register |
| ramWrite | output | 1 | Write the bus into RAM at the loaded address |
| manualCtl | output | 1 | High while the loader overrides the control unit |
| bootDone | output | 1 | One-cycle pulse when control is handed back |

## Verification
A wrong phase bit shows within two cycles: marLoad and ramWrite land on the wrong cycle parity, or a RAM address is loaded with ROM data. A counter that skips or stalls shows in romAddr at the next address cycle, and later as RAM contents that are shifted against the image. A faulty end test shows either as a stray write of 0xFF, or as bootDone arriving at a cycle other than 2s+2. The bench compares every output in every cycle against that schedule, and compares the RAM image at the end of each copy.

// File: rtl/boot_loader_pkg.sv
package boot_loader_pkg;

  typedef struct packed {
    logic addrPhase;  // drive counter on bus, load RAM address
    logic dataPhase;  // drive ROM word on bus
    logic writeEn;    // commit the bus word into RAM
    logic advance;    // step the copy counter
  } strobe_t;

endpackage

// File: rtl/boot_ctrl.sv
module boot_ctrl
  import boot_loader_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    sentinelHit,
  input  logic    atLast,
  output strobe_t strb,
  output logic    active,
  output logic    donePulse
);

  logic phaseQ;
  logic activeQ;
  logic doneQ;
  logic finishing;

  assign finishing = activeQ && phaseQ && (sentinelHit || atLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ  <= 1'b0;
      activeQ <= 1'b1;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= finishing;
      if (activeQ) begin
        phaseQ <= ~phaseQ;
      end
      if (finishing) begin
        activeQ <= 1'b0;
      end
    end
  end

  always_comb begin
    strb.addrPhase = activeQ && !phaseQ;
    strb.dataPhase = activeQ && phaseQ;
    strb.writeEn   = activeQ && phaseQ && !sentinelHit;
    strb.advance   = activeQ && phaseQ && !sentinelHit && !atLast;
  end

  assign active    = activeQ;
  assign donePulse = doneQ;

endmodule

// File: rtl/boot_datapath.sv
module boot_datapath
  import boot_loader_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] romData,
  output logic [ADDR_W-1:0] romAddr,
  output logic [DATA_W-1:0] busOut,
  output logic              sentinelHit,
  output logic              atLast
);

  localparam logic [DATA_W-1:0] END_MARK  = '1;
  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

  logic [ADDR_W-1:0] cnt;
  logic [DATA_W-1:0] addrOnBus;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strb.advance) begin
      cnt <= cnt + 1'b1;
    end
  end

  generate
    if (DATA_W > ADDR_W) begin : g_pad
      assign addrOnBus = {{(DATA_W-ADDR_W){1'b0}}, cnt};
    end else begin : g_same
      assign addrOnBus = DATA_W'(cnt);
    end
  endgenerate

  always_comb begin
    if (strb.addrPhase) begin
      busOut = addrOnBus;
    end else if (strb.dataPhase) begin
      busOut = romData;
    end else begin
      busOut = '0;
    end
  end

  assign sentinelHit = (romData == END_MARK);
  assign atLast      = (cnt == LAST_ADDR);
  assign romAddr     = cnt;

endmodule

// File: rtl/boot_loader.sv
module boot_loader
  import boot_loader_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] romData,
  output logic [ADDR_W-1:0] romAddr,
  output logic [DATA_W-1:0] busOut,
  output logic              marLoad,
  output logic              ramWrite,
  output logic              manualCtl,
  output logic              bootDone
);

  strobe_t strb;
  logic    sentinelHit;
  logic    atLast;

  boot_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sentinelHit(sentinelHit),
    .atLast     (atLast),
    .strb       (strb),
    .active     (manualCtl),
    .donePulse  (bootDone)
  );

  boot_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .romData    (romData),
    .romAddr    (romAddr),
    .busOut     (busOut),
    .sentinelHit(sentinelHit),
    .atLast     (atLast)
  );

  assign marLoad  = strb.addrPhase;
  assign ramWrite = strb.writeEn;

endmodule

// File: rtl/boot_loader_checks.sv
module boot_loader_checks #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] romData,
  input logic [ADDR_W-1:0] romAddr,
  input logic [DATA_W-1:0] busOut,
  input logic              marLoad,
  input logic              ramWrite,
  input logic              manualCtl,
  input logic              bootDone
);

  localparam logic [DATA_W-1:0] END_MARK = '1;

  AST_ADDR_THEN_DATA: assert property (@(posedge clk) disable iff (!rstN)
    marLoad |=> !marLoad); // R2

  AST_WRITE_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    ramWrite |-> $past(marLoad)); // R3

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ramWrite |-> $stable(romAddr)); // R4

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (marLoad && $past(ramWrite)) |-> (romAddr == ADDR_W'($past(romAddr) + 1'b1))); // R4

  AST_MARK_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (manualCtl && !marLoad && romData == END_MARK) |-> !ramWrite); // R5

  AST_RELEASE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !manualCtl |=> !manualCtl); // R6

  AST_QUIET_AFTER: assert property (@(posedge clk) disable iff (!rstN)
    !manualCtl |-> (!marLoad && !ramWrite && busOut == '0)); // R6

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    bootDone |=> !bootDone); // R7

  AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(manualCtl) |-> bootDone); // R7

endmodule

bind boot_loader boot_loader_checks #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) i_checks (
  .clk      (clk),
  .rstN     (rstN),
  .romData  (romData),
  .romAddr  (romAddr),
  .busOut   (busOut),
  .marLoad  (marLoad),
  .ramWrite (ramWrite),
  .manualCtl(manualCtl),
  .bootDone (bootDone)
);

// File: tb/test_boot_loader.sv
module test_boot_loader;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;

  typedef struct packed {
    logic [8:0] sent;    // marker address, 256 = none
    logic [7:0] seed;
    logic [8:0] writes;  // expected words written
    logic [9:0] doneCyc; // expected bootDone cycle
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{9'd0,   8'd3,  9'd0,   10'd2},
    '{9'd1,   8'd5,  9'd1,   10'd4},
    '{9'd5,   8'd7,  9'd5,   10'd12},
    '{9'd37,  8'd11, 9'd37,  10'd76},
    '{9'd254, 8'd13, 9'd254, 10'd510},
    '{9'd255, 8'd17, 9'd255, 10'd512},
    '{9'd256, 8'd19, 9'd256, 10'd512}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] romData = 8'h00;
  logic [7:0] romAddr;
  logic [7:0] busOut;
  logic       marLoad, ramWrite, manualCtl, bootDone;

  logic [7:0] rom [256];
  logic [7:0] ram [256];
  logic       written [256];
  logic [7:0] mar = 8'h00;
  int         wrCount = 0;
  int         checks = 0;
  int         failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_loader i_boot_loader (
    .clk(clk), .rstN(rstN), .romData(romData), .romAddr(romAddr),
    .busOut(busOut), .marLoad(marLoad), .ramWrite(ramWrite),
    .manualCtl(manualCtl), .bootDone(bootDone)
  );

  // synchronous ROM and RAM models
  always @(posedge clk) begin
    romData <= rom[romAddr];
    if (marLoad) mar <= busOut;
    if (ramWrite) begin
      ram[mar] <= busOut;
      written[mar] <= 1'b1;
      wrCount <= wrCount + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] outs();
    return {manualCtl, marLoad, ramWrite, bootDone, busOut, romAddr};
  endfunction

  task automatic prepare(input vec_t v);
    for (int i = 0; i < 256; i++) begin
      logic [7:0] w;
      w = 8'((i * v.seed) + 8'h11);
      if (w == 8'hFF) w = 8'h00;
      if (i == int'(v.sent)) w = 8'hFF;
      rom[i] = w;
      ram[i] = 8'h00;
      written[i] = 1'b0;
    end
    wrCount = 0;
  endtask

  task automatic hold_reset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    #(CLK_PERIOD/4);
    check("R1 reset state", 32'(outs()), 32'({4'b1100, 8'h00, 8'h00}));
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic run_case(input vec_t v);
    prepare(v);
    hold_reset();
    for (int k = 0; k <= int'(v.doneCyc) + 3; k++) begin
      #(CLK_PERIOD/4);
      if (k < int'(v.doneCyc)) begin
        int a;
        a = k / 2;
        if (k % 2 == 0) begin
          check(k == 0 ? "R1 first cycle" : "R2,R4 address cycle",
                32'(outs()), 32'({4'b1100, 8'(a), 8'(a)}));
        end else if (a == int'(v.sent)) begin
          check("R5 marker cycle", 32'(outs()), 32'({4'b1000, rom[a], 8'(a)}));
        end else begin
          check(a == 255 ? "R8 last data cycle" : "R3,R4 data cycle",
                32'(outs()), 32'({4'b1010, rom[a], 8'(a)}));
        end
      end else if (k == int'(v.doneCyc)) begin
        check("R7 done cycle", 32'(outs() >> 8), 32'({4'b0001, 8'h00}));
      end else begin
        check("R6 released", 32'(outs() >> 8), 32'({4'b0000, 8'h00}));
      end
      @(negedge clk);
    end
    begin
      int badData;
      int stray;
      badData = 0;
      stray = 0;
      for (int i = 0; i < 256; i++) begin
        if (i < int'(v.writes)) begin
          if (ram[i] !== rom[i] || !written[i]) badData++;
        end else if (written[i]) begin
          stray++;
        end
      end
      check(v.sent == 9'd256 ? "R8 write count" : "R5 write count",
            32'(wrCount), 32'(v.writes));
      check("R3 RAM image mismatches", 32'(badData), 32'd0);
      check("R5 writes beyond marker", 32'(stray), 32'd0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int n = 0; n < NVEC; n++) begin
      run_case(VECS[n]);
    end

    // R9: reset in the middle of a copy restarts from address 0
    prepare(VECS[3]);
    hold_reset();
    repeat (9) @(negedge clk);
    rstN = 1'b0;
    #(CLK_PERIOD/4);
    check("R9 reset mid-copy", 32'(outs()), 32'({4'b1100, 8'h00, 8'h00}));
    @(negedge clk);
    rstN = 1'b1;
    #(CLK_PERIOD/4);
    check("R9 restart address cycle", 32'(outs()), 32'({4'b1100, 8'h00, 8'h00}));
    @(negedge clk);
    #(CLK_PERIOD/4);
    check("R9 restart data cycle", 32'(outs()), 32'({4'b1010, rom[0], 8'h00}));
    @(negedge clk);
    #(CLK_PERIOD/4);
    check("R9 restart second address", 32'(outs()), 32'({4'b1100, 8'h01, 8'h01}));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule